// File: doc/BRIEF.md
# Serial Peripheral Master with Word Queues

This block is a register-mapped master for a four-wire serial peripheral link. Software programs a configuration word that holds the bit-rate divisor, the word length, the clock idle level, the clock phase and an enable bit. It then queues outbound words through a single data port and writes a start command. Each outbound word carries its own end-of-transfer flag. After the flagged word has been shifted, the block raises a completion event and releases its select line. Words captured on the input line go into a receive queue, which software drains through the same data port.

Events latch in a write-one-to-clear register. A mask register picks which events drive the interrupt output. The events cover queue space available, received data present, completion, receive overflow, transmit underflow, and a second master seen driving the select line.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the select output is high, the serial clock is low, the interrupt is low, the queues are empty and the status register reads 0x02.
- R2: With divisor value d (configuration bits 5:0), each serial clock half period lasts d+1 block clock cycles.
- R3: Configuration bit 9 sets the clock idle level and bit 10 sets the capture edge (0: first edge of a bit, 1: second edge). In all four combinations, words go out most significant bit first and loop back intact. The clock rests at the idle level whenever no word is shifting.
- R4: Configuration bits 8:6 hold the word length minus one. Only the low n bits of a queued word are sent, and received words hold n bits, zero-extended.
- R5: Data port writes put bits 7:0 in the outbound queue, with bit 8 as the end flag. Shifting stops after the flagged word: event bit 2 (done) sets and the select output returns high.
- R6: Command register (address 1) bits: 0 clears the receive queue, 1 clears the outbound queue, 2 starts. Nothing shifts before a start, and a start is ignored while the enable bit (configuration bit 11) is clear.
- R7: Status register (address 2) bits: 0 outbound queue full, 1 receive queue empty, 2 ready (enable set), 3 interrupt pending, 4 busy.
- R8: Event register (address 3) bits are cleared by writing 1 to them.
- R9: The interrupt output is high exactly when an event bit and its mask bit (address 4) are both set.
- R10: Event bit 0 sets while the outbound queue has a free entry. Event bit 1 sets while the receive queue holds a word.
- R11: Reading the data port (address 5) pops the receive queue and returns the word in bits 7:0.
- R12: Each queue holds 8 words. A word received into a full receive queue is dropped and sets event bit 3.
- R13: If the outbound queue is empty when the next word is needed before the flagged word has been sent, event bit 4 sets, the select output goes high and the clock rests at its idle level.
- R14: Event bit 5 sets when the external select input is low while this block drives its own select low. It does not set while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the bit-rate base |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | output | 1 | Active-low peripheral select |
| ext_sel_n | input | 1 | Select line seen from other masters |
| irq | output | 1 | Masked event summary |

## Verification
The assertions assume that the configuration register is left unchanged while a transfer runs, because the idle-level and clock-stability properties compare the clock against the live idle-level bit. They also assume that each register access is a single-cycle strobe. The stimulus reprograms the configuration only after busy has dropped. It drives every access as a one-cycle pulse on the falling edge. The serial input is looped back from the serial output, so any phase or ordering error shows up as data corruption.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
   localparam int EV_TXREQ = 0;
   localparam int EV_RXREQ = 1;
   localparam int EV_DONE  = 2;
   localparam int EV_RXOVF = 3;
   localparam int EV_TXUF  = 4;
   localparam int EV_MULTI = 5;
   localparam int EV_COUNT = 6;

   localparam logic [2:0] RA_CFG  = 3'd0;
   localparam logic [2:0] RA_CMD  = 3'd1;
   localparam logic [2:0] RA_STAT = 3'd2;
   localparam logic [2:0] RA_EVT  = 3'd3;
   localparam logic [2:0] RA_MASK = 3'd4;
   localparam logic [2:0] RA_DATA = 3'd5;

   typedef enum logic [1:0] {E_IDLE, E_FETCH, E_SHIFT} eng_state_e;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("queue depth must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; cnt <= '0;
      end else if (clr) begin
         wp <= '0; rp <= '0; cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> full);
   p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !clr) |=> empty);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_fifo_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int RATE_W = 6,
   parameter int LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [RATE_W-1:0] rate,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic              tx_empty,
   input  logic [WORD_W:0]   tx_word,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [WORD_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              sel_n,
   output logic              done_pulse,
   output logic              uf_pulse
);
   eng_state_e        st;
   logic [RATE_W-1:0] cnt;
   logic              half, last_q, tick, word_end;
   logic [LEN_W-1:0]  bits;
   logic [WORD_W-1:0] sh, rv, wmask, rv_next;

   assign tick       = (st == E_SHIFT) && (cnt == rate);
   assign word_end   = tick && half && (bits == len_m1);
   assign rv_next    = {rv[WORD_W-2:0], miso};
   assign wmask      = {WORD_W{1'b1}} >> (LEN_W'(WORD_W - 1) - len_m1);
   assign rx_word    = (cpha ? rv_next : rv) & wmask;
   assign rx_push    = word_end;
   assign done_pulse = word_end && last_q;
   assign tx_pop     = (st == E_FETCH) && !tx_empty;
   assign uf_pulse   = (st == E_FETCH) && tx_empty;
   assign mosi       = (st == E_SHIFT) ? sh[len_m1] : 1'b0;
   assign sclk       = cpol ^ ((st == E_SHIFT) && half);
   assign sel_n      = (st == E_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= E_IDLE; cnt <= '0; half <= 1'b0; bits <= '0;
         last_q <= 1'b0; sh <= '0; rv <= '0;
      end else begin
         case (st)
            E_IDLE: if (start) st <= E_FETCH;
            E_FETCH: begin
               if (tx_empty) st <= E_IDLE;
               else begin
                  sh     <= tx_word[WORD_W-1:0];
                  last_q <= tx_word[WORD_W];
                  cnt    <= '0;
                  half   <= 1'b0;
                  bits   <= '0;
                  st     <= E_SHIFT;
               end
            end
            default: begin
               if (!tick) cnt <= cnt + 1'b1;
               else begin
                  cnt  <= '0;
                  half <= !half;
                  if (!half) begin
                     if (!cpha) rv <= rv_next;
                     else if (bits != '0) sh <= sh << 1;
                  end else begin
                     if (!cpha) sh <= sh << 1;
                     else rv <= rv_next;
                     bits <= bits + 1'b1;
                     if (bits == len_m1) st <= last_q ? E_IDLE : E_FETCH;
                  end
               end
            end
         endcase
      end
   end

   p_done_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> sel_n);
   p_uf_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_pulse && $stable(cpol)) |=> (sel_n && sclk == cpol));
   p_half_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_SHIFT && !tick) |=> (sclk == $past(sclk) || cpol != $past(cpol)));
   p_idle_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_IDLE && !start) |=> st == E_IDLE);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
   import spi_fifo_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int FIFO_DEPTH = 8,
   parameter int RATE_W     = 6,
   parameter int BUS_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             sclk,
   output logic             mosi,
   input  logic             miso,
   output logic             sel_n,
   input  logic             ext_sel_n,
   output logic             irq
);
   localparam int LEN_W   = $clog2(WORD_W);
   localparam int CFG_INV = RATE_W + LEN_W;
   localparam int CFG_DLY = CFG_INV + 1;
   localparam int CFG_EN  = CFG_INV + 2;
   localparam int CFG_W   = CFG_INV + 3;

   generate
      if (WORD_W < 2 || (1 << LEN_W) != WORD_W) begin : g_bad_word
         $error("word width must be a power of two of at least 2");
      end
      if (BUS_W < CFG_W || BUS_W < WORD_W + 1) begin : g_bad_bus
         $error("bus too narrow for configuration or data word");
      end
   endgenerate

   logic [CFG_W-1:0]    cfg;
   logic [EV_COUNT-1:0] evt, msk, ev_set;
   logic wr, rd, cmd_wr, start, rx_clr, tx_clr, tx_push, rx_pop;
   logic tx_full, tx_empty, tx_pop, rx_full, rx_empty, rx_push;
   logic done_pulse, uf_pulse, eng_sel_n;
   logic [WORD_W:0]   tx_word;
   logic [WORD_W-1:0] rx_word, rx_dout;

   assign wr      = bus_sel && bus_wr;
   assign rd      = bus_sel && !bus_wr;
   assign cmd_wr  = wr && (bus_addr == RA_CMD);
   assign rx_clr  = cmd_wr && bus_wdata[0];
   assign tx_clr  = cmd_wr && bus_wdata[1];
   assign start   = cmd_wr && bus_wdata[2] && cfg[CFG_EN] && eng_sel_n;
   assign tx_push = wr && (bus_addr == RA_DATA);
   assign rx_pop  = rd && (bus_addr == RA_DATA);

   spi_word_fifo #(.WIDTH(WORD_W + 1), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
      .din(bus_wdata[WORD_W:0]), .pop(tx_pop), .dout(tx_word),
      .full(tx_full), .empty(tx_empty));

   spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push),
      .din(rx_word), .pop(rx_pop), .dout(rx_dout),
      .full(rx_full), .empty(rx_empty));

   spi_shift_engine #(.WORD_W(WORD_W), .RATE_W(RATE_W), .LEN_W(LEN_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cpol(cfg[CFG_INV]), .cpha(cfg[CFG_DLY]),
      .rate(cfg[RATE_W-1:0]), .len_m1(cfg[RATE_W +: LEN_W]),
      .tx_empty(tx_empty), .tx_word(tx_word), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_word(rx_word),
      .sclk(sclk), .mosi(mosi), .miso(miso), .sel_n(eng_sel_n),
      .done_pulse(done_pulse), .uf_pulse(uf_pulse));

   assign sel_n = eng_sel_n;

   always_comb begin
      ev_set           = '0;
      ev_set[EV_TXREQ] = !tx_full;
      ev_set[EV_RXREQ] = !rx_empty;
      ev_set[EV_DONE]  = done_pulse;
      ev_set[EV_RXOVF] = rx_push && rx_full;
      ev_set[EV_TXUF]  = uf_pulse;
      ev_set[EV_MULTI] = !eng_sel_n && !ext_sel_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0; evt <= '0; msk <= '0;
      end else begin
         if (wr && bus_addr == RA_CFG)  cfg <= bus_wdata[CFG_W-1:0];
         if (wr && bus_addr == RA_MASK) msk <= bus_wdata[EV_COUNT-1:0];
         evt <= (evt & ~((wr && bus_addr == RA_EVT) ? bus_wdata[EV_COUNT-1:0]
                                                    : {EV_COUNT{1'b0}})) | ev_set;
      end
   end

   assign irq = |(evt & msk);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_CFG:  bus_rdata = BUS_W'(cfg);
         RA_STAT: bus_rdata = BUS_W'({!eng_sel_n, irq, cfg[CFG_EN], rx_empty, tx_full});
         RA_EVT:  bus_rdata = BUS_W'(evt);
         RA_MASK: bus_rdata = BUS_W'(msk);
         RA_DATA: bus_rdata = BUS_W'(rx_dout);
         default: bus_rdata = '0;
      endcase
   end

   p_start_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_sel_n && cmd_wr && !cfg[CFG_EN]) |=> sel_n);
   p_multi_flag_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !ext_sel_n) |=> evt[EV_MULTI]);
   p_done_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> evt[EV_DONE]);
endmodule

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic sclk, mosi, miso, sel_n, irq;
   logic ext_sel_n = 1'b1;
   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;
   assign miso = mosi;

   spi_fifo_master uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sclk(sclk), .mosi(mosi), .miso(miso), .sel_n(sel_n),
      .ext_sel_n(ext_sel_n), .irq(irq));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bw(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic br(logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   function automatic logic [15:0] mk_cfg(bit dly, bit inv, int len_m1, int rate);
      return 16'((1 << 11) | (int'(dly) << 10) | (int'(inv) << 9) | (len_m1 << 6) | rate);
   endfunction

   task automatic wait_idle();
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (sel_n) break;
      end
   endtask

   task automatic prep(logic [15:0] cfgv);
      bw(3'd0, cfgv);
      bw(3'd1, 16'h3);
      bw(3'd3, 16'h3F);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      check("R1 sel_n", sel_n, 1);
      check("R1 sclk", sclk, 0);
      check("R1 irq", irq, 0);
      br(3'd2, d); check("R1 R7 status", d, 16'h02);
      br(3'd3, d); check("R10 txreq after reset", d, 16'h01);
   endtask

   task automatic t_gate();
      logic [15:0] d;
      bw(3'd0, 16'h0001);
      bw(3'd5, 16'h1AA);
      bw(3'd1, 16'h4);
      repeat (20) @(negedge clk);
      check("R6 start ignored when disabled", sel_n, 1);
      br(3'd2, d); check("R6 nothing received", d[1], 1);
      for (int i = 0; i < 7; i++) bw(3'd5, 16'(i));
      br(3'd2, d); check("R7 tx full flag", d[0], 1);
      bw(3'd1, 16'h2);
      br(3'd2, d); check("R6 tx clear", d[0], 0);
   endtask

   task automatic t_mode(int m);
      logic [15:0] d;
      logic [7:0] w [3];
      w[0] = 8'hA5 ^ 8'(m); w[1] = 8'h3C + 8'(m); w[2] = 8'h81;
      prep(mk_cfg(m[0], m[1], 7, 1));
      check("R3 idle level", sclk, 1'(m[1]));
      bw(3'd5, {8'h00, w[0]});
      bw(3'd5, {8'h00, w[1]});
      bw(3'd5, {8'h01, w[2]});
      bw(3'd1, 16'h4);
      wait_idle();
      check("R5 select released", sel_n, 1);
      check("R3 clock at idle after", sclk, 1'(m[1]));
      br(3'd3, d); check("R5 done event", d[2], 1);
      bw(3'd3, 16'h04);
      br(3'd3, d); check("R8 done cleared", d[2], 0);
      for (int i = 0; i < 3; i++) begin
         br(3'd5, d); check($sformatf("R3 R11 mode%0d word%0d", m, i), d, {8'h00, w[i]});
      end
   endtask

   task automatic t_rate();
      int k;
      prep(mk_cfg(0, 0, 7, 3));
      bw(3'd5, 16'h1FF);
      bw(3'd1, 16'h4);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (sclk) break;
      end
      k = 1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (sclk) k++; else break;
      end
      check("R2 half period", k, 4);
      wait_idle();
   endtask

   task automatic t_len();
      logic [15:0] d;
      int edges;
      logic prev;
      prep(mk_cfg(0, 0, 3, 1));
      bw(3'd5, 16'h1A5);
      bw(3'd1, 16'h4);
      edges = 0; prev = sclk;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (sclk && !prev) edges++;
         prev = sclk;
         if (sel_n) break;
      end
      check("R4 four clock pulses", edges, 4);
      br(3'd5, d); check("R4 short word", d, 16'h0005);
   endtask

   task automatic t_overflow();
      logic [15:0] d;
      prep(mk_cfg(0, 0, 7, 0));
      for (int i = 0; i < 8; i++) bw(3'd5, 16'(i * 17 + 3));
      bw(3'd1, 16'h4);
      bw(3'd5, 16'h100 | 16'(8 * 17 + 3));
      wait_idle();
      br(3'd3, d); check("R12 overflow event", d[3], 1);
      bw(3'd3, 16'h02);
      br(3'd3, d); check("R10 rxreq persists", d[1], 1);
      for (int i = 0; i < 8; i++) begin
         br(3'd5, d); check($sformatf("R12 kept word%0d", i), d, 16'(i * 17 + 3));
      end
      br(3'd2, d); check("R12 ninth dropped", d[1], 1);
      bw(3'd3, 16'h02);
      br(3'd3, d); check("R10 rxreq clear when empty", d[1], 0);
   endtask

   task automatic t_underflow();
      logic [15:0] d;
      prep(mk_cfg(0, 1, 7, 1));
      bw(3'd5, 16'h011);
      bw(3'd5, 16'h022);
      bw(3'd1, 16'h4);
      wait_idle();
      br(3'd3, d); check("R13 underflow event", d[4], 1);
      check("R13 clock idle", sclk, 1);
      check("R13 select high", sel_n, 1);
      bw(3'd4, 16'h00);
      check("R9 masked off", irq, 0);
      bw(3'd4, 16'h10);
      check("R9 unmasked", irq, 1);
      br(3'd2, d); check("R7 irq pending", d[3], 1);
      bw(3'd3, 16'h10);
      check("R8 R9 cleared", irq, 0);
      bw(3'd4, 16'h00);
   endtask

   task automatic t_multi();
      logic [15:0] d;
      prep(mk_cfg(0, 0, 7, 7));
      @(negedge clk); ext_sel_n = 1'b0;
      repeat (3) @(negedge clk); ext_sel_n = 1'b1;
      br(3'd3, d); check("R14 idle ignores", d[5], 0);
      bw(3'd5, 16'h055);
      bw(3'd5, 16'h1AA);
      bw(3'd1, 16'h4);
      repeat (5) @(negedge clk);
      ext_sel_n = 1'b0;
      @(negedge clk); ext_sel_n = 1'b1;
      wait_idle();
      br(3'd3, d); check("R14 multi master", d[5], 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_gate();
      for (int m = 0; m < 4; m++) t_mode(m);
      t_rate();
      t_len();
      t_overflow();
      t_underflow();
      t_multi();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule